// File: doc/BRIEF.md
# Router Functional Test Flit Generator

This block produces the functional test stimulus for a single five-port wormhole router that has two virtual channels. It walks every combination of input port, output direction and virtual channel. For each of these triplets it emits a fixed group of eight 34-bit flits. Each flit carries a 2-bit flit-type field in its top bits. The remaining bits are 2-bit digits, and each digit stands for one 1-of-4 code on the asynchronous link. Within a flit every data digit holds the same value, so across a triplet each digit takes all four codes.

A second mode emits a short four-vector sequence for testing a bare network link. In this sequence all seventeen digits carry one repeated value, and a send bit alternates from vector to vector.

Flits leave over a valid/ready interface. A companion triplet index tells the response checker which triplet the current flit belongs to. Checking the router's responses is outside this block.

The controller has four states and five transitions:

- `ST_IDLE` goes to `ST_ROUTER` on a start pulse with the link mode low, and to `ST_LINK` on a start pulse with the link mode high.
- `ST_ROUTER` and `ST_LINK` each go to `ST_DONE` when the final vector is accepted.
- `ST_DONE` always returns to `ST_IDLE` after one cycle.

Top module: `rtvg_top`

## Requirements
- R1: After reset, valid and done are low and the triplet index is 0.
- R2: A start pulse in idle begins a run. The first vector is valid in the cycle after the start is sampled, and without a start valid stays low.
- R3: A router run emits 320 vectors in this order: input port (slowest), then direction, then virtual channel, then vector number 0..7 (fastest). For vector n, the triplet index is n/8, which equals (port*4+direction)*2+vc, and chan_tag equals vc, which is (n/8) mod 2.
- R4: In a router run, bits 33:32 carry the flit type. Vectors 0..3 are single-flit packets (11), vector 4 is a header (01), vectors 5 and 6 are bodies (00) and vector 7 is a tail (10).
- R5: Single-flit and header vectors hold the direction in bits 1:0. Every 2-bit digit in bits 31:2 equals the vector number mod 4.
- R6: Body and tail vectors hold every 2-bit digit of bits 31:0 equal to the vector number mod 4.
- R7: A link run emits 4 vectors. For vector k, all 17 digits of bits 33:0 equal 3-k, chan_tag runs 1,0,1,0 and the triplet index stays 0.
- R8: The block advances only when valid and ready are both high. While valid is high and ready is low, the flit, chan_tag and triplet index hold and valid stays high.
- R9: Done is high for exactly one cycle, the cycle after the final vector is accepted. Valid is low in that cycle and the block then returns to idle.
- R10: A start pulse during a run or during the done cycle is ignored.
- R11: The link mode input is sampled only together with an accepted start. Changing it mid-run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| link_mode | input | 1 | 1 selects the link sequence, 0 the router sweep |
| ready | input | 1 | Downstream accepts the current flit |
| flit | output | 34 | Test flit |
| chan_tag | output | 1 | Virtual channel (router run) or send bit (link run) |
| valid | output | 1 | Flit is valid |
| trip_idx | output | 6 | Index of the current input/direction/VC triplet |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
The bench sweeps all 320 router vectors and all four link vectors, with ready held high and with ready pulled low in a regular stall pattern. Every accepted flit is compared against a value the bench computes from the vector count.

- A wrong nesting of the counters would put the virtual channel or the direction in the wrong position, which shows up as a mismatched triplet index or direction digit.
- A block that advanced on valid alone would skip vectors under stalls and so break the held-flit check.
- An off-by-one in the terminal count would emit 319 or 321 vectors, or raise done a cycle late.
- Starts injected mid-run and in the done cycle would restart or corrupt a block that honoured them.

// File: rtl/rtvg_pkg.sv
package rtvg_pkg;
    localparam int DIG_W        = 2;
    localparam int FLIT_W       = 34;
    localparam int N_DIR        = 4;
    localparam int VEC_PER_TRIP = 8;
    localparam int LINK_VECS    = 4;
    localparam int VEC_W        = $clog2(VEC_PER_TRIP);
    localparam int DIR_W        = $clog2(N_DIR);

    localparam logic [1:0] FT_BODY   = 2'b00;
    localparam logic [1:0] FT_HEAD   = 2'b01;
    localparam logic [1:0] FT_TAIL   = 2'b10;
    localparam logic [1:0] FT_SINGLE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUTER,
        ST_LINK,
        ST_DONE
    } gen_state_t;
endpackage

// File: rtl/rtvg_seq.sv
module rtvg_seq
    import rtvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       link_mode,
    input  logic       ready,
    input  logic       last,
    output gen_state_t state,
    output logic       step,
    output logic       clear,
    output logic       valid,
    output logic       done
);
    gen_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        valid    = 1'b0;
        done     = 1'b0;
        clear    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear = 1'b1;
                if (start) state_nx = link_mode ? ST_LINK : ST_ROUTER;
            end
            ST_ROUTER, ST_LINK: begin
                valid = 1'b1;
                if (ready && last) state_nx = ST_DONE;
            end
            ST_DONE: begin
                done     = 1'b1;
                clear    = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        step = valid && ready;
    end
endmodule

// File: rtl/rtvg_index_ctr.sv
module rtvg_index_ctr
    import rtvg_pkg::*;
#(
    parameter int N_IN = 5,
    parameter int N_VC = 2,
    localparam int PW  = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int VCW = (N_VC > 1) ? $clog2(N_VC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             link_sel,
    output logic [PW-1:0]    port_q,
    output logic [DIR_W-1:0] dir_q,
    output logic [VCW-1:0]   vc_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             last
);
    logic vec_wrap, vc_wrap, dir_wrap, port_wrap;

    always_comb begin
        vec_wrap  = link_sel ? (vec_q == VEC_W'(LINK_VECS - 1))
                             : (vec_q == VEC_W'(VEC_PER_TRIP - 1));
        dir_wrap  = (dir_q == DIR_W'(N_DIR - 1));
        port_wrap = (port_q == PW'(N_IN - 1));
        last      = link_sel ? vec_wrap
                             : (vec_wrap && vc_wrap && dir_wrap && port_wrap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vec_q  <= '0;
            dir_q  <= '0;
            port_q <= '0;
        end else if (step) begin
            vec_q <= vec_wrap ? '0 : vec_q + 1'b1;
            if (vec_wrap && vc_wrap && !link_sel) begin
                dir_q <= dir_wrap ? '0 : dir_q + 1'b1;
                if (dir_wrap) port_q <= port_wrap ? '0 : port_q + 1'b1;
            end
        end
    end

    generate
        if (N_VC > 1) begin : g_vc_count
            assign vc_wrap = (vc_q == VCW'(N_VC - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    vc_q <= '0;
                else if (step && vec_wrap && !link_sel)
                    vc_q <= vc_wrap ? '0 : vc_q + 1'b1;
            end
        end else begin : g_vc_fixed
            assign vc_wrap = 1'b1;
            assign vc_q    = '0;
        end
    endgenerate
endmodule

// File: rtl/rtvg_flit_build.sv
module rtvg_flit_build
    import rtvg_pkg::*;
#(
    parameter int N_VC = 2,
    localparam int VCW = (N_VC > 1) ? $clog2(N_VC) : 1
) (
    input  logic              link_sel,
    input  logic [DIR_W-1:0]  dir,
    input  logic [VCW-1:0]    vc,
    input  logic [VEC_W-1:0]  vec,
    output logic [FLIT_W-1:0] flit,
    output logic              tag
);
    localparam int N_DIGITS = FLIT_W / DIG_W;

    logic [DIG_W-1:0] fill;
    logic [1:0]       ftype;

    always_comb begin
        flit  = '0;
        ftype = FT_BODY;
        if (link_sel) begin
            fill = DIG_W'(LINK_VECS - 1) - DIG_W'(vec);
            for (int i = 0; i < N_DIGITS; i++) flit[i*DIG_W +: DIG_W] = fill;
            tag = ~vec[0];
        end else begin
            fill = vec[DIG_W-1:0];
            if (vec < VEC_W'(4))      ftype = FT_SINGLE;
            else if (vec == VEC_W'(4)) ftype = FT_HEAD;
            else if (vec == VEC_W'(7)) ftype = FT_TAIL;
            else                       ftype = FT_BODY;
            for (int i = 0; i < N_DIGITS - 1; i++) flit[i*DIG_W +: DIG_W] = fill;
            if (ftype == FT_SINGLE || ftype == FT_HEAD) flit[DIR_W-1:0] = dir;
            flit[FLIT_W-1 -: 2] = ftype;
            tag = vc[0];
        end
    end
endmodule

// File: rtl/rtvg_top.sv
module rtvg_top
    import rtvg_pkg::*;
#(
    parameter int N_IN = 5,
    parameter int N_VC = 2,
    localparam int N_TRIP = N_IN * N_DIR * N_VC,
    localparam int TRIP_W = $clog2(N_TRIP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              link_mode,
    input  logic              ready,
    output logic [FLIT_W-1:0] flit,
    output logic              chan_tag,
    output logic              valid,
    output logic [TRIP_W-1:0] trip_idx,
    output logic              done
);
    localparam int PW  = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int VCW = (N_VC > 1) ? $clog2(N_VC) : 1;

    gen_state_t       state;
    logic             step, clear, last, link_sel;
    logic [PW-1:0]    port_q;
    logic [DIR_W-1:0] dir_q;
    logic [VCW-1:0]   vc_q;
    logic [VEC_W-1:0] vec_q;
    int               trip_calc;

    assign link_sel = (state == ST_LINK);

    rtvg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .link_mode (link_mode),
        .ready     (ready),
        .last      (last),
        .state     (state),
        .step      (step),
        .clear     (clear),
        .valid     (valid),
        .done      (done)
    );

    rtvg_index_ctr #(.N_IN(N_IN), .N_VC(N_VC)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .link_sel (link_sel),
        .port_q   (port_q),
        .dir_q    (dir_q),
        .vc_q     (vc_q),
        .vec_q    (vec_q),
        .last     (last)
    );

    rtvg_flit_build #(.N_VC(N_VC)) u_build (
        .link_sel (link_sel),
        .dir      (dir_q),
        .vc       (vc_q),
        .vec      (vec_q),
        .flit     (flit),
        .tag      (chan_tag)
    );

    always_comb begin
        trip_calc = (int'(port_q) * N_DIR + int'(dir_q)) * N_VC + int'(vc_q);
        trip_idx  = link_sel ? '0 : TRIP_W'(trip_calc);
    end
endmodule

// File: rtl/rtvg_chk.sv
module rtvg_chk
    import rtvg_pkg::*;
#(
    parameter int N_IN = 5,
    parameter int N_VC = 2,
    localparam int N_TRIP = N_IN * N_DIR * N_VC,
    localparam int TRIP_W = $clog2(N_TRIP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              valid,
    input logic              done,
    input logic [FLIT_W-1:0] flit,
    input logic              chan_tag,
    input logic [TRIP_W-1:0] trip_idx,
    input gen_state_t        st
);
    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(flit) && $stable(chan_tag) && $stable(trip_idx)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    // R5
    dir_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && st == ST_ROUTER && flit[FLIT_W-2])
            |-> (int'(flit[1:0]) == (int'(trip_idx) / N_VC) % N_DIR));

    // R3
    trip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(trip_idx) < N_TRIP);

    // R7
    link_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LINK) |-> (trip_idx == '0));
endmodule

bind rtvg_top rtvg_chk #(.N_IN(N_IN), .N_VC(N_VC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .valid    (valid),
    .done     (done),
    .flit     (flit),
    .chan_tag (chan_tag),
    .trip_idx (trip_idx),
    .st       (state)
);

// File: tb/rtvg_top_test.sv
`timescale 1ns/1ps
module rtvg_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        link_mode = 1'b0;
    logic        ready = 1'b0;
    logic [33:0] flit;
    logic        chan_tag;
    logic        valid;
    logic [5:0]  trip_idx;
    logic        done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rtvg_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .link_mode (link_mode),
        .ready     (ready),
        .flit      (flit),
        .chan_tag  (chan_tag),
        .valid     (valid),
        .trip_idx  (trip_idx),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [33:0] exp_flit(input bit lk, input int n);
        logic [33:0] f;
        int k, v, d, typ;
        f = '0;
        if (lk) begin
            v = 3 - n;
            for (int i = 0; i < 17; i++) f[2*i +: 2] = 2'(v);
        end else begin
            k = n % 8;
            v = k % 4;
            d = (n / 16) % 4;
            typ = (k < 4) ? 3 : (k == 4) ? 1 : (k == 7) ? 2 : 0;
            for (int i = 0; i < 16; i++) f[2*i +: 2] = 2'(v);
            if (typ == 3 || typ == 1) f[1:0] = 2'(d);
            f[33:32] = 2'(typ);
        end
        return f;
    endfunction

    task automatic run(input bit lk, input int total, input int stall_mod,
                       input int intrude_at);
        int n = 0;
        int cyc = 0;
        bit stalled = 0;
        bit fired_last = 0;
        bit done_seen = 0;
        bit rdy;
        logic [33:0] h_flit;
        logic h_tag;
        logic [5:0] h_trip;
        string rq;
        @(negedge clk);
        start = 1'b1;
        link_mode = lk;
        @(negedge clk);
        start = 1'b0;
        link_mode = ~lk;  // R11: mode changes after start must not matter
        chk(valid === 1'b1, "R2", "valid after start", valid, 1);
        while (!done_seen && cyc < 4000) begin
            if (stalled) begin
                chk(valid === 1'b1 && flit === h_flit && chan_tag === h_tag && trip_idx === h_trip,
                    "R8", "hold while stalled", flit, h_flit);
            end
            if (done) begin
                chk(n == total && fired_last, "R9", "done after final vector", n, total);
                chk(valid === 1'b0, "R9", "valid low with done", valid, 0);
                done_seen = 1;
                start = 1'b1;  // R10: start during the done cycle
                link_mode = lk;
                @(negedge clk);
                start = 1'b0;
                chk(valid === 1'b0 && done === 1'b0, "R10", "start in done cycle ignored",
                    valid, 0);
                @(negedge clk);
                chk(valid === 1'b0, "R10", "still idle", valid, 0);
            end else begin
                rdy = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 1);
                ready = rdy;
                fired_last = 0;
                if (valid && rdy) begin
                    if (n >= total) begin
                        chk(0, lk ? "R7" : "R3", "extra vector", n, total);
                    end else begin
                        if (lk) rq = "R7";
                        else if ((n % 8) <= 4) rq = "R5";
                        else rq = "R6";
                        chk(flit === exp_flit(lk, n), rq, "flit content", flit, exp_flit(lk, n));
                        if (!lk)
                            chk(flit[33:32] === exp_flit(0, n) >> 32, "R4", "flit type",
                                flit[33:32], exp_flit(0, n) >> 32);
                        chk(chan_tag === (lk ? (n % 2 == 0) : ((n / 8) % 2 == 1)),
                            lk ? "R7" : "R3", "chan_tag", chan_tag,
                            lk ? (n % 2 == 0) : ((n / 8) % 2));
                        chk(trip_idx === 6'(lk ? 0 : n / 8), lk ? "R7" : "R3", "trip_idx",
                            trip_idx, lk ? 0 : n / 8);
                    end
                    n++;
                    fired_last = (n == total);
                end else if (!valid) begin
                    chk(0, "R8", "valid dropped mid-run", valid, 1);
                end
                stalled = valid && !rdy;
                h_flit = flit;
                h_tag = chan_tag;
                h_trip = trip_idx;
                if (cyc == intrude_at) begin
                    start = 1'b1;  // R10: start during a run
                    link_mode = ~lk;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        ready = 1'b0;
        if (!done_seen) chk(0, "R9", "run never finished", n, total);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0, "R1", "outputs in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0, "R1", "idle after reset", {valid, done}, 0);
        chk(trip_idx === 6'd0, "R1", "trip_idx after reset", trip_idx, 0);
        repeat (4) @(negedge clk);
        chk(valid === 1'b0, "R2", "no start keeps idle", valid, 0);
        run(1'b0, 320, 0, -1);
        run(1'b0, 320, 3, 100);
        run(1'b1, 4, 0, -1);
        run(1'b1, 4, 2, 1);
        run(1'b0, 320, 5, 7);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule